// File: doc/BRIEF.md
# MII Transmit Phase Aligner

This block sits between a 25 MHz MII transmit datapath and the PHY pins. It delays the transmit enable and the 4-bit transmit nibble by zero to three cycles of a 100 MHz clock, which gives 0, 10, 20 or 30 ns. The 100 MHz clock is phase-locked to the 25 MHz clock and shares its source with the PHY's transmit clock. The block places the output transitions where the PHY's setup and hold window allows, with no transmit FIFO.

The 25 MHz launch point reaches the block as a 2-bit phase count on the fast clock. The count wraps every four fast cycles. Its value 0 marks the fast cycle in which a new 25 MHz word is presented. The delay is chosen in one of two ways. In manual mode the PHY transmit clock input is tied low and a 2-bit setting selects the delay. In automatic mode the PHY clock is connected and the manual setting is held at zero. The block then finds the phase of the PHY clock and selects the delay itself. The block instance serves one port, and each port uses its own instance.

Top module: `mii_tx_phase_align`

## Requirements
- R1: During reset and on the first cycle after it, `tx_en_o`, `txd_o`, `shift_o` and `lock_o` are all zero.
- R2: With an applied shift of N (0..3), `txd_o` in any fast cycle equals `txd_i` from N fast cycles earlier. For N = 0 this is the same cycle.
- R3: `tx_en_o` is delayed by exactly the same N cycles as `txd_o`, so enable and data stay aligned.
- R4: The PHY clock passes through a two-flop synchronizer. Each rising edge seen at its output records the current phase count. `lock_o` rises only when 8 consecutive recorded edges carry the same phase value. It stays low before that.
- R5: The shift chosen once locked is the recorded phase value plus 2, modulo 4. This puts output transitions 20 ns away from the detected edge. At the port this means: if `phy_txclk_i` is first high in a fast cycle where `phase_ref` = p, the locked shift is p.
- R6: While unlocked, the shift requested is `shift_man_i`. Tying the PHY clock low therefore gives manual operation, and an unlocked automatic port defaults to zero.
- R7: A recorded edge whose phase differs from the stored one restarts the count at one and drops `lock_o`.
- R8: A requested shift is applied only at the end of a fast cycle where `phase_ref` = 0, `tx_en_i` is low, and no delayed enable is still in the taps. A frame in progress keeps its shift.
- R9: `shift_o` reports the applied shift and `lock_o` reports the lock flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | 100 MHz clock, phase-locked to the 25 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_ref | input | 2 | Phase of the 25 MHz period, 0 = launch cycle |
| tx_en_i | input | 1 | Transmit enable from the 25 MHz datapath |
| txd_i | input | 4 | Transmit nibble from the 25 MHz datapath |
| phy_txclk_i | input | 1 | PHY transmit clock, tied low for manual mode |
| shift_man_i | input | 2 | Manual shift in 10 ns steps |
| tx_en_o | output | 1 | Delayed transmit enable to the PHY |
| txd_o | output | 4 | Delayed transmit nibble to the PHY |
| shift_o | output | 2 | Applied shift |
| lock_o | output | 1 | Automatic phase detection locked |

## Verification
The data outputs follow the inputs N fast cycles later. Tap 0 is combinational, so the outputs change in the same cycle. The bench drives the inputs just after each falling edge and compares the outputs 1 ns later against a four-deep history of what it drove. The applied shift changes one fast cycle after a qualifying phase-0 cycle, so the bench reads `shift_o` only after at least two full idle 25 MHz periods. Lock needs 8 recorded edges plus the three-cycle synchronizer and edge-detect latency. The bench therefore samples `lock_o` at 4 periods, where it must still be low, and at 16 periods, where it must be high. It never samples at the exact edge of the lock transition.

// File: rtl/mii_tx_phase_align.sv
module mii_tx_phase_align #(
  parameter int DW     = 4,
  parameter int LOCK_N = 8
) (
  input  logic          clk_fast,
  input  logic          rst_n,
  input  logic [1:0]    phase_ref,
  input  logic          tx_en_i,
  input  logic [DW-1:0] txd_i,
  input  logic          phy_txclk_i,
  input  logic [1:0]    shift_man_i,
  output logic          tx_en_o,
  output logic [DW-1:0] txd_o,
  output logic [1:0]    shift_o,
  output logic          lock_o
);
  localparam int CW = $clog2(LOCK_N + 1);

  logic [DW:0]   tap [1:3];
  logic [DW:0]   tap0;
  logic [DW:0]   sel;
  logic [2:0]    sync_q;
  logic          rise;
  logic [1:0]    edge_ph;
  logic [CW-1:0] cnt;
  logic [1:0]    shift_q;
  logic [1:0]    shift_req;
  logic          idle;

  assign tap0 = {tx_en_i, txd_i};

  always_ff @(posedge clk_fast) begin
    if (!rst_n) begin
      tap[1] <= '0;
      tap[2] <= '0;
      tap[3] <= '0;
    end else begin
      tap[1] <= tap0;
      tap[2] <= tap[1];
      tap[3] <= tap[2];
    end
  end

  always_comb begin
    case (shift_q)
      2'd0:    sel = tap0;
      2'd1:    sel = tap[1];
      2'd2:    sel = tap[2];
      default: sel = tap[3];
    endcase
  end

  assign tx_en_o = sel[DW];
  assign txd_o   = sel[DW-1:0];

  always_ff @(posedge clk_fast) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], phy_txclk_i};
  end

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk_fast) begin
    if (!rst_n) begin
      edge_ph <= '0;
      cnt     <= '0;
    end else if (rise) begin
      if (cnt != 0 && phase_ref == edge_ph) begin
        if (cnt != CW'(LOCK_N)) cnt <= cnt + 1'b1;
      end else begin
        edge_ph <= phase_ref;
        cnt     <= CW'(1);
      end
    end
  end

  assign lock_o    = (cnt == CW'(LOCK_N));
  assign shift_req = lock_o ? edge_ph + 2'd2 : shift_man_i;
  assign idle      = !tx_en_i && !tap[1][DW] && !tap[2][DW] && !tap[3][DW];

  always_ff @(posedge clk_fast) begin
    if (!rst_n)                       shift_q <= '0;
    else if (phase_ref == 2'd0 && idle) shift_q <= shift_req;
  end

  assign shift_o = shift_q;

  p_shift_hold_r8: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $past(rst_n) && (shift_q != $past(shift_q)) |->
      $past(phase_ref) == 2'd0 && !$past(tx_en_i));

  p_tap_one_r2: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $past(rst_n) && shift_q == 2'd1 && $past(shift_q) == 2'd1 |->
      txd_o == $past(txd_i) && tx_en_o == $past(tx_en_i));

  p_lock_on_edge_r4: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $past(rst_n) && $rose(lock_o) |-> $past(rise));

  p_unlock_on_edge_r7: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $past(rst_n) && $fell(lock_o) |-> $past(rise) && $past(phase_ref) != $past(edge_ph));

  p_frame_shift_r3: assert property (@(posedge clk_fast) disable iff (!rst_n)
    tx_en_o |=> $stable(shift_q) || !$past(tx_en_o));
endmodule

// File: tb/tb_mii_tx_phase_align.sv
module tb_mii_tx_phase_align;
  logic       clk_fast = 0;
  logic       rst_n = 0;
  logic [1:0] phase_ref = 2'd3;
  logic       tx_en_i = 0;
  logic [3:0] txd_i = 0;
  logic       phy_txclk_i = 0;
  logic [1:0] shift_man_i = 0;
  logic       tx_en_o;
  logic [3:0] txd_o;
  logic [1:0] shift_o;
  logic       lock_o;

  int checks = 0;
  int fails = 0;
  logic       pcon = 0;
  logic [1:0] off = 0;
  logic       he [0:3];
  logic [3:0] hd [0:3];

  mii_tx_phase_align dut (.*);

  always #5 clk_fast = ~clk_fast;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [3:0] d, input bit dochk, input int n);
    @(negedge clk_fast);
    phase_ref = phase_ref + 2'd1;
    if (phase_ref == 2'd0) begin
      tx_en_i = en;
      txd_i   = d;
    end
    phy_txclk_i = pcon && (((phase_ref - off) & 2'd3) < 2'd2);
    for (int i = 3; i > 0; i--) begin
      he[i] = he[i-1];
      hd[i] = hd[i-1];
    end
    he[0] = tx_en_i;
    hd[0] = txd_i;
    #1;
    if (dochk) begin
      chk("R2 data", txd_o, hd[n]);
      chk("R3 enable", tx_en_o, he[n]);
    end
  endtask

  task automatic word(input logic en, input logic [3:0] d, input bit dochk, input int n);
    for (int k = 0; k < 4; k++) step(en, d, dochk, n);
  endtask

  task automatic idle(input int periods);
    for (int k = 0; k < periods; k++) word(1'b0, 4'h0, 1'b0, 0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) begin he[i] = 0; hd[i] = 0; end
    idle(2);
    chk("R1 en", tx_en_o, 0);
    chk("R1 shift", shift_o, 0);
    chk("R1 lock", lock_o, 0);
    @(negedge clk_fast); rst_n = 1;
    phase_ref = phase_ref + 2'd1;
    for (int i = 3; i > 0; i--) begin he[i] = he[i-1]; hd[i] = hd[i-1]; end
    he[0] = 0; hd[0] = 0;
    while (phase_ref != 2'd3) step(1'b0, 4'h0, 1'b0, 0);
    #1;
    chk("R1 txd", txd_o, 0);
    chk("R1 lock after", lock_o, 0);
  endtask

  task automatic t_manual(input int n);
    shift_man_i = 2'(n);
    idle(3);
    chk("R6 manual shift", shift_o, n);
    chk("R9 unlocked", lock_o, 0);
    for (int k = 0; k < 6; k++) word(k % 3 != 2, 4'(k * 5 + n + 1), 1'b1, n);
    idle(2);
  endtask

  task automatic t_auto(input logic [1:0] o);
    shift_man_i = 0;
    off  = o;
    pcon = 1;
    idle(4);
    chk("R4 not yet locked", lock_o, 0);
    idle(12);
    chk("R4 locked", lock_o, 1);
    chk("R5 auto shift", shift_o, o);
    for (int k = 0; k < 5; k++) word(k != 4, 4'(9 + k), 1'b1, o);
    idle(2);
  endtask

  task automatic t_relock(input logic [1:0] o_new, input logic [1:0] o_old);
    for (int k = 0; k < 2; k++) word(1'b1, 4'(k + 3), 1'b0, 0);
    off = o_new;
    for (int k = 0; k < 3; k++) word(1'b1, 4'(k + 6), 1'b0, 0);
    chk("R7 lock dropped", lock_o, 0);
    chk("R8 shift held in frame", shift_o, o_old);
    idle(2);
    chk("R8 shift applied when idle", shift_o, 0);
    idle(12);
    chk("R4 relocked", lock_o, 1);
    chk("R5 new auto shift", shift_o, o_new);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_manual(0);
        t_manual(1);
        t_manual(2);
        t_manual(3);
        shift_man_i = 0;
        idle(2);
        t_auto(2'd1);
        t_relock(2'd3, 2'd1);
      end
      begin
        repeat (20000) @(posedge clk_fast);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule